// File: doc/BRIEF.md
# Bank Command Timing Guard

This block sits between the command scheduler of a memory controller and a four-bank DDR SDRAM. Each cycle the scheduler presents at most one command, made of a valid strobe, a 3-bit command code and a bank index. In the same cycle the guard answers with exactly one verdict. The verdict is `grant` when the command may go to the device now, `stall` when it is legal but a timing rule still blocks it, or `illegal` when it makes no sense for the current bank state. A granted command updates the bank state at the next rising clock edge. A stalled or illegal command changes nothing, so the scheduler can simply present it again.

Command codes are: 0 activate, 1 read, 2 write, 3 write with auto-precharge, 4 precharge. Codes 5 to 7 are unused.

For each bank the guard tracks whether a row is open. It also keeps saturating down-counters for the rules that apply to that bank: row-to-read delay, row-to-write delay, write recovery before precharge, and precharge or auto-precharge before the next activate. Two shared counters protect the data bus. One holds reads back while a write burst is still on the bus. The other holds writes back until the read data, which arrives after the CAS latency, has left the bus. Every delay is a parameter. The defaults are read-after-activate 4, write-after-activate 2, precharge-to-activate 4, write recovery 2, auto-precharge-write-to-activate 7, CAS latency 4 and burst length 4 (two clock cycles of data).

Top module: `bank_cmd_guard`

## Requirements
- R1: After reset every bank is closed (`bank_open` = 0). A granted activate opens its bank. A granted precharge or write with auto-precharge closes it. The flag changes at the edge that ends the grant cycle.
- R2: A read to a bank is granted no earlier than T_RCD_RD (4) cycles after that bank's activate.
- R3: A write or write with auto-precharge is granted no earlier than T_RCD_WR (2) cycles after that bank's activate.
- R4: A precharge to a bank is granted no earlier than BL/2 + T_WR (4) cycles after a write to that bank.
- R5: An activate is granted no earlier than T_RP (4) cycles after a precharge to that bank.
- R6: An activate is granted no earlier than T_DAL (7) cycles after a write with auto-precharge to that bank.
- R7: A read to any bank is granted no earlier than BL/2 (2) cycles after any write, so a read never cuts into a write burst.
- R8: A write to any bank is granted no earlier than CL + BL/2 (6) cycles after any read.
- R9: A read or write (either code) to a closed bank, an activate to an open bank, and codes 5 to 7 raise `illegal`. They are never granted and leave the bank flags unchanged.
- R10: A precharge to a closed bank is granted and has no effect. In particular, it does not start a precharge-to-activate wait.
- R11: A bank that has been idle since reset is eligible at once. A timing wait on one bank does not delay commands to another bank.
- R12: `grant`, `stall` and `illegal` are mutually exclusive, and all three are low while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command is presented this cycle |
| req_cmd | input | 3 | Command code (0 act, 1 rd, 2 wr, 3 wr+auto-pre, 4 pre) |
| req_bank | input | 2 | Target bank |
| grant | output | 1 | Command may issue this cycle |
| stall | output | 1 | Command is legal but blocked by a timing rule |
| illegal | output | 1 | Command is invalid for the bank state |
| bank_open | output | 4 | Per-bank open-row flags |

## Verification
The verdict outputs are combinational, so the verdict for a command is due in the same cycle it is presented. The bench drives each request on the falling edge and samples the verdict shortly afterwards. It then lets the rising edge commit the request. `bank_open` is due one cycle after the grant, and the bench reads it on the next falling edge with the request withdrawn. Each timing rule is tested by presenting the blocked command once per cycle from the cycle after the enabling command. The expected result is stall up to the cycle before the rule's count and grant exactly on that count, so an off-by-one in either direction produces a mismatch.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

  typedef enum logic [2:0] {
    CMD_ACT = 3'd0,
    CMD_RD  = 3'd1,
    CMD_WR  = 3'd2,
    CMD_WRA = 3'd3,
    CMD_PRE = 3'd4
  } guard_cmd_e;

  // Value loaded into a down-counter so that the blocked command is
  // first allowed exactly `cycles` cycles after the loading command.
  function automatic int wait_load(input int cycles);
    return (cycles > 1) ? cycles - 1 : 0;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wait_counter.sv
module wait_counter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (load)      cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
  import bank_guard_pkg::*;
#(
  parameter int CW        = 3,
  parameter int T_RCD_RD  = 4,
  parameter int T_RCD_WR  = 2,
  parameter int T_RP      = 4,
  parameter int WR_TO_PRE = 4,
  parameter int T_DAL     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_act,
  input  logic ev_wr,
  input  logic ev_wra,
  input  logic ev_pre,
  output logic open_o,
  output logic rd_ok,
  output logic wr_ok,
  output logic pre_ok,
  output logic act_ok
);
  localparam logic [CW-1:0] L_RCD_RD = CW'(wait_load(T_RCD_RD));
  localparam logic [CW-1:0] L_RCD_WR = CW'(wait_load(T_RCD_WR));
  localparam logic [CW-1:0] L_WR_PRE = CW'(wait_load(WR_TO_PRE));
  localparam logic [CW-1:0] L_RP     = CW'(wait_load(T_RP));
  localparam logic [CW-1:0] L_DAL    = CW'(wait_load(T_DAL));

  logic open_q;
  logic act_load;
  logic [CW-1:0] act_val;

  always_ff @(posedge clk) begin
    if (!rst_n)                 open_q <= 1'b0;
    else if (ev_act)            open_q <= 1'b1;
    else if (ev_pre || ev_wra)  open_q <= 1'b0;
  end
  assign open_o = open_q;

  assign act_load = ev_pre || ev_wra;
  assign act_val  = ev_wra ? L_DAL : L_RP;

  wait_counter #(.CW(CW)) u_rcd_rd (.clk(clk), .rst_n(rst_n), .load(ev_act),
    .load_val(L_RCD_RD), .done(rd_ok));
  wait_counter #(.CW(CW)) u_rcd_wr (.clk(clk), .rst_n(rst_n), .load(ev_act),
    .load_val(L_RCD_WR), .done(wr_ok));
  wait_counter #(.CW(CW)) u_wr_pre (.clk(clk), .rst_n(rst_n), .load(ev_wr),
    .load_val(L_WR_PRE), .done(pre_ok));
  wait_counter #(.CW(CW)) u_act    (.clk(clk), .rst_n(rst_n), .load(act_load),
    .load_val(act_val), .done(act_ok));

  p_act_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |=> open_o);
  p_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pre || ev_wra) |=> !open_o);

  generate
    if (T_RCD_RD > 1) begin : g_a_rd
      p_rcd_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_act |=> !rd_ok);
    end
    if (T_RCD_WR > 1) begin : g_a_wr
      p_rcd_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_act |=> !wr_ok);
    end
    if (WR_TO_PRE > 1) begin : g_a_pre
      p_wr_recovery_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wr |=> !pre_ok);
    end
    if (T_RP > 1) begin : g_a_rp
      p_rp_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pre |=> !act_ok);
    end
    if (T_DAL > 1) begin : g_a_dal
      p_dal_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wra |=> !act_ok);
    end
  endgenerate
endmodule

// File: rtl/bus_turnaround.sv
module bus_turnaround
  import bank_guard_pkg::*;
#(
  parameter int CW       = 3,
  parameter int WR_BUSY  = 2,
  parameter int RD_TO_WR = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_any_wr,
  input  logic ev_any_rd,
  output logic rd_free,
  output logic wr_free
);
  localparam logic [CW-1:0] L_WBUSY = CW'(wait_load(WR_BUSY));
  localparam logic [CW-1:0] L_RD2WR = CW'(wait_load(RD_TO_WR));

  wait_counter #(.CW(CW)) u_wburst (.clk(clk), .rst_n(rst_n), .load(ev_any_wr),
    .load_val(L_WBUSY), .done(rd_free));
  wait_counter #(.CW(CW)) u_rdturn (.clk(clk), .rst_n(rst_n), .load(ev_any_rd),
    .load_val(L_RD2WR), .done(wr_free));

  generate
    if (WR_BUSY > 1) begin : g_a_wb
      p_no_rd_in_wburst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_any_wr |=> !rd_free);
    end
    if (RD_TO_WR > 1) begin : g_a_rw
      p_rd_to_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_any_rd |=> !wr_free);
    end
  endgenerate
endmodule

// File: rtl/bank_cmd_guard.sv
module bank_cmd_guard
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BL        = 4,
  parameter int T_RCD_RD  = 4,
  parameter int T_RCD_WR  = 2,
  parameter int T_RP      = 4,
  parameter int T_WR      = 2,
  parameter int T_DAL     = 7,
  parameter int CL        = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [2:0]                   req_cmd,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  output logic                         grant,
  output logic                         stall,
  output logic                         illegal,
  output logic [NUM_BANKS-1:0]         bank_open
);
  localparam int WR_TO_PRE = BL / 2 + T_WR;
  localparam int WR_BUSY   = BL / 2;
  localparam int RD_TO_WR  = CL + BL / 2;
  localparam int MAXT = max2(max2(max2(T_RCD_RD, T_RCD_WR), max2(T_RP, T_DAL)),
                             max2(max2(WR_TO_PRE, WR_BUSY), RD_TO_WR));
  localparam int CW = $clog2(MAXT + 1);

  logic [NUM_BANKS-1:0] rd_ok, wr_ok, pre_ok, act_ok, sel;
  logic rd_free, wr_free;
  logic is_act, is_rd, is_wr, is_wra, is_pre, tgt_open, legal, timing_ok;

  assign is_act = (req_cmd == CMD_ACT);
  assign is_rd  = (req_cmd == CMD_RD);
  assign is_wr  = (req_cmd == CMD_WR);
  assign is_wra = (req_cmd == CMD_WRA);
  assign is_pre = (req_cmd == CMD_PRE);
  assign tgt_open = bank_open[req_bank];

  always_comb begin
    legal = 1'b0;
    if (is_act)                      legal = !tgt_open;
    else if (is_rd || is_wr || is_wra) legal = tgt_open;
    else if (is_pre)                 legal = 1'b1;
  end

  always_comb begin
    timing_ok = 1'b0;
    if (is_act)               timing_ok = act_ok[req_bank];
    else if (is_rd)           timing_ok = rd_ok[req_bank] && rd_free;
    else if (is_wr || is_wra) timing_ok = wr_ok[req_bank] && wr_free;
    else if (is_pre)          timing_ok = pre_ok[req_bank];
  end

  assign grant   = req_valid && legal && timing_ok;
  assign stall   = req_valid && legal && !timing_ok;
  assign illegal = req_valid && !legal;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign sel[b] = grant && (req_bank == b);
      bank_tracker #(
        .CW(CW), .T_RCD_RD(T_RCD_RD), .T_RCD_WR(T_RCD_WR),
        .T_RP(T_RP), .WR_TO_PRE(WR_TO_PRE), .T_DAL(T_DAL)
      ) u_trk (
        .clk(clk), .rst_n(rst_n),
        .ev_act(sel[b] && is_act),
        .ev_wr(sel[b] && is_wr),
        .ev_wra(sel[b] && is_wra),
        .ev_pre(sel[b] && is_pre && bank_open[b]),
        .open_o(bank_open[b]),
        .rd_ok(rd_ok[b]), .wr_ok(wr_ok[b]),
        .pre_ok(pre_ok[b]), .act_ok(act_ok[b])
      );
    end
  endgenerate

  bus_turnaround #(.CW(CW), .WR_BUSY(WR_BUSY), .RD_TO_WR(RD_TO_WR)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .ev_any_wr(grant && (is_wr || is_wra)),
    .ev_any_rd(grant && is_rd),
    .rd_free(rd_free), .wr_free(wr_free)
  );

  p_closed_never_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (is_rd || is_wr || is_wra) && !bank_open[req_bank]) |-> !grant);
  p_open_act_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_act && bank_open[req_bank]) |=> $stable(bank_open));
  p_verdict_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant, stall, illegal}));
  p_quiet_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(grant || stall || illegal));
endmodule

// File: tb/bank_cmd_guard_tb_top.sv
module bank_cmd_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] ACT = 3'd0, RD = 3'd1, WR = 3'd2, WRA = 3'd3, PRE = 3'd4;
  localparam int V_GRANT = 1, V_STALL = 2, V_ILL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [1:0] req_bank = 2'd0;
  logic grant, stall, illegal;
  logic [3:0] bank_open;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_cmd_guard dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_bank(req_bank), .grant(grant), .stall(stall),
    .illegal(illegal), .bank_open(bank_open));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // present one command for one cycle; verdict: 1 grant, 2 stall, 3 illegal
  task automatic try_cmd(input logic [2:0] c, input logic [1:0] b, input int exp_v,
                         input string tag);
    int v;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_bank = b;
    #1;
    v = grant ? V_GRANT : stall ? V_STALL : illegal ? V_ILL : 0;
    if (int'(grant) + int'(stall) + int'(illegal) > 1) v = 9;
    check(tag, v, exp_v);
  endtask

  task automatic idle_chk_open(input logic [3:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(tag, int'(bank_open), int'(exp));
    check({tag, " idle verdict R12"}, int'({grant, stall, illegal}), 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); req_valid = 1'b0;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    idle_chk_open(4'b0000, "R1 reset closed");
    try_cmd(ACT, 2'd3, V_GRANT, "R11 idle bank act at once");
    idle_chk_open(4'b1000, "R1 act opens");
  endtask

  task automatic t_rcd_read();
    do_reset();
    try_cmd(ACT, 2'd0, V_GRANT, "R2 act");
    for (int i = 1; i < 4; i++) try_cmd(RD, 2'd0, V_STALL, "R2 rd early");
    try_cmd(RD, 2'd0, V_GRANT, "R2 rd on time");
  endtask

  task automatic t_rcd_write_recovery_rp();
    do_reset();
    try_cmd(ACT, 2'd1, V_GRANT, "R3 act");
    try_cmd(WR, 2'd1, V_STALL, "R3 wr early");
    try_cmd(WR, 2'd1, V_GRANT, "R3 wr on time");
    for (int i = 1; i < 4; i++) try_cmd(PRE, 2'd1, V_STALL, "R4 pre early");
    try_cmd(PRE, 2'd1, V_GRANT, "R4 pre on time");
    idle_chk_open(4'b0000, "R1 pre closes");
    for (int i = 2; i < 4; i++) try_cmd(ACT, 2'd1, V_STALL, "R5 act early");
    try_cmd(ACT, 2'd1, V_GRANT, "R5 act on time");
  endtask

  task automatic t_auto_pre();
    do_reset();
    try_cmd(ACT, 2'd2, V_GRANT, "R6 act");
    idle(1);
    try_cmd(WRA, 2'd2, V_GRANT, "R3 wra on time");
    idle_chk_open(4'b0000, "R1 wra closes");
    for (int i = 2; i < 7; i++) try_cmd(ACT, 2'd2, V_STALL, "R6 act early");
    try_cmd(ACT, 2'd2, V_GRANT, "R6 act on time");
  endtask

  task automatic t_bus_turn();
    do_reset();
    try_cmd(ACT, 2'd0, V_GRANT, "R7 act b0");
    try_cmd(ACT, 2'd3, V_GRANT, "R11 act b3 not held by b0");
    idle(4);
    try_cmd(WR, 2'd3, V_GRANT, "R7 wr b3");
    try_cmd(RD, 2'd0, V_STALL, "R7 rd in burst");
    try_cmd(RD, 2'd0, V_GRANT, "R7 rd after burst");
    for (int i = 1; i < 6; i++) try_cmd(WR, 2'd3, V_STALL, "R8 wr early");
    try_cmd(WR, 2'd3, V_GRANT, "R8 wr on time");
  endtask

  task automatic t_illegal();
    do_reset();
    try_cmd(RD, 2'd1, V_ILL, "R9 rd closed");
    try_cmd(WRA, 2'd1, V_ILL, "R9 wra closed");
    idle_chk_open(4'b0000, "R9 no open after illegal");
    try_cmd(ACT, 2'd1, V_GRANT, "R9 act");
    try_cmd(ACT, 2'd1, V_ILL, "R9 act open");
    try_cmd(3'd6, 2'd1, V_ILL, "R9 unused code");
    idle_chk_open(4'b0010, "R9 flags kept");
  endtask

  task automatic t_pre_closed();
    do_reset();
    try_cmd(PRE, 2'd2, V_GRANT, "R10 pre closed");
    try_cmd(ACT, 2'd2, V_GRANT, "R10 act right after");
    try_cmd(ACT, 2'd0, V_GRANT, "R11 other bank");
    try_cmd(PRE, 2'd2, V_GRANT, "R5 pre b2");
    try_cmd(ACT, 2'd0, V_ILL, "R9 b0 already open");
    try_cmd(PRE, 2'd0, V_GRANT, "R11 pre b0 independent");
    idle_chk_open(4'b0000, "R1 both closed");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_rcd_read();
    t_rcd_write_recovery_rp();
    t_auto_pre();
    t_bus_turn();
    t_illegal();
    t_pre_closed();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule